// File: doc/BRIEF.md
# Two-Wire Display Controller Slave with Read-Ahead Data Register

This block is the serial front end of a character display controller. It sits on a two-wire I2C bus as a slave at the fixed 7-bit address 0111010. Both bus lines are sampled by a fast system clock. In write mode the master sends control bytes. Each control byte chooses the instruction or data register, announces the direction of a later read, and says whether another control byte follows. The block carries out two instructions: return home, which clears the address counter, and set address, which loads the counter and fetches display RAM. Data bytes written in write mode are acknowledged and dropped.

The read path goes through a data register that always holds the next byte to send. When the slave acknowledges a read address, the register's current contents go out first. Each later byte is fetched from the display RAM at the moment the master acknowledges the previous one, and the address counter then advances. When the master does not acknowledge, the fetch is skipped and the counter stays where it is. The display RAM is outside the block. The block presents an address and reads a byte back in the same cycle.

Top module: `disp_i2c_slave`

## Requirements
- R1: Only an address byte whose upper seven bits are 0111010 is acknowledged (bit 0 is R/W: 0 write, 1 read). After a mismatch the slave acknowledges nothing and changes nothing until the next START.
- R2: In a control byte, bit 7 is Co, bit 6 is RS and bit 5 is R/W, and every control byte is acknowledged. With Co=1 exactly one payload byte follows and the byte after it is a control byte again. With Co=0 every following byte of the transfer is payload.
- R3: The instruction 0x02, sent with RS=0, sets the address counter to 0 and leaves the data register unchanged.
- R4: The instruction 1aaaaaaa with a below 80, sent with RS=0, loads the data register from RAM location a and sets the counter to a+1, where 79 is followed by 0. When a is 80 or more the instruction is ignored, and the counter stays below 80 at all times.
- R5: A read address is acknowledged only when the last control byte carried RS=1 and R/W=1. Otherwise it is not acknowledged.
- R6: The first byte sent after the read address is the data register's contents. Bytes are sent MSB first. The slave releases SDA during every master acknowledge slot and changes its SDA drive only while SCL is low.
- R7: On a master acknowledge, RAM at the counter is loaded into the data register and becomes the next byte sent, and the counter then increments with wrap at 80.
- R8: On a master non-acknowledge nothing is loaded, the counter does not move, and the slave leaves SDA released until the next START.
- R9: A STOP returns the slave to idle with SDA released, even in the middle of a byte. A later START with a matching address is acknowledged.
- R10: After reset SDA is released, the counter is 0 and the data register is 0x00.
- R11: Payload bytes with RS=1 in write mode, and instruction bytes that are neither 0x02 nor set address, are acknowledged and change neither the counter nor the data register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level |
| sdaOe | output | 1 | 1 pulls the data line low (open-drain) |
| ramAddr | output | 7 | Display RAM read address (equal to the address counter when idle) |
| ramData | input | 8 | Display RAM byte at ramAddr, same cycle |

## Verification
Reads are run after a set address at random RAM locations, with random burst lengths. Comparing each byte with the bench's RAM image separates the byte held in the data register from the byte fetched at each master acknowledge. It also catches bit-order and off-by-one counter errors. Directed patterns cover several cases, each aimed at a different fault:
- Set address at the last location, which exposes counter wrap.
- Return home followed by a read, whose first byte must still be the stale register value.
- A set address with an out-of-range operand.
- Streams of Co=1 and Co=0 control bytes whose payload would move the counter if it were parsed as the wrong kind of byte.
- Reads refused because the control byte had the wrong direction.
- A foreign address.
- A STOP in the middle of a byte.
- A non-acknowledged read followed by extra clocks, during which the data line must stay high.

// File: rtl/disp_i2c_pkg.sv
package disp_i2c_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CTRL,
    ST_PAY,
    ST_READ,
    ST_WAIT
  } busState_t;

  // strobes from control to datapath, each valid for one clock
  typedef struct packed {
    logic rxShift;   // shift the sampled data bit into the receive byte
    logic txLoad;    // copy the data register into the transmit shifter
    logic txShift;   // advance the transmit shifter by one bit
    logic fetch;     // master ack: RAM to data register and shifter, counter + 1
    logic home;      // counter to zero
    logic setAddr;   // counter from instruction, data register from RAM
  } dpStrobe_t;

endpackage

// File: rtl/disp_i2c_dpath.sv
module disp_i2c_dpath
  import disp_i2c_pkg::*;
#(
  parameter int DEPTH = 80
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpStrobe_t  strb,
  input  logic       sdaBit,
  input  logic [7:0] ramData,
  output logic [7:0] rxByte,
  output logic [1:0] txHead,
  output logic [6:0] ramAddr
);

  localparam logic [6:0] LAST_LOC = 7'(DEPTH - 1);

  logic [7:0] rxReg;
  logic [7:0] txReg;
  logic [7:0] dataReg;
  logic [6:0] addrCnt;

  function automatic logic [6:0] stepAddr(input logic [6:0] a);
    return (a == LAST_LOC) ? 7'd0 : a + 7'd1;
  endfunction

  // during a set-address the RAM is read at the operand, otherwise at the counter
  assign ramAddr = strb.setAddr ? rxReg[6:0] : addrCnt;
  assign rxByte  = rxReg;
  assign txHead  = txReg[7:6];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxReg   <= '0;
      txReg   <= '0;
      dataReg <= '0;
      addrCnt <= '0;
    end else begin
      if (strb.rxShift) rxReg <= {rxReg[6:0], sdaBit};

      if (strb.txLoad)       txReg <= dataReg;
      else if (strb.fetch)   txReg <= ramData;
      else if (strb.txShift) txReg <= {txReg[6:0], 1'b0};

      if (strb.fetch || strb.setAddr) dataReg <= ramData;

      if (strb.home)         addrCnt <= '0;
      else if (strb.setAddr) addrCnt <= stepAddr(rxReg[6:0]);
      else if (strb.fetch)   addrCnt <= stepAddr(addrCnt);
    end
  end

endmodule

// File: rtl/disp_i2c_ctrl.sv
module disp_i2c_ctrl
  import disp_i2c_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR  = 7'b0111010,
  parameter int         DEPTH       = 80,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [7:0] rxByte,
  input  logic [1:0] txHead,
  output logic       sdaOe,
  output logic       sdaBit,
  output dpStrobe_t  strb,
  output busState_t  state,
  output logic       sclLevel,
  output logic       stopEv,
  output logic       rsFlag,
  output logic       rwFlag
);

  localparam logic [7:0] DEPTH_B = 8'(DEPTH);
  localparam logic [3:0] BIT_LAST = 4'd8;
  localparam logic [3:0] BIT_ACK  = 4'd9;

  logic [SYNC_STAGES-1:0] sclPipe;
  logic [SYNC_STAGES-1:0] sdaPipe;
  logic sclS, sdaS, sclPrev, sdaPrev;
  logic sclRise, sclFall, startEv;
  logic [3:0] bitCnt;
  logic sdaLow;
  logic coFlag;
  logic addrHit, readOk, isRecv;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclS     = sclPipe[SYNC_STAGES-1];
  assign sdaS     = sdaPipe[SYNC_STAGES-1];
  assign sclRise  = sclS & ~sclPrev;
  assign sclFall  = ~sclS & sclPrev;
  assign startEv  = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopEv   = sclS & sclPrev & ~sdaPrev & sdaS;
  assign sdaBit   = sdaS;
  assign sclLevel = sclS;
  assign sdaOe    = sdaLow;

  assign addrHit = (rxByte[7:1] == SLAVE_ADDR);
  assign readOk  = rsFlag & rwFlag;
  assign isRecv  = (state == ST_ADDR) || (state == ST_CTRL) || (state == ST_PAY);

  always_comb begin
    strb = '0;
    if (!startEv && !stopEv) begin
      if (isRecv && sclRise && bitCnt < BIT_LAST) strb.rxShift = 1'b1;
      if (state == ST_ADDR && sclFall && bitCnt == BIT_LAST &&
          addrHit && rxByte[0] && readOk)
        strb.txLoad = 1'b1;
      if (state == ST_PAY && sclFall && bitCnt == BIT_LAST && !rsFlag) begin
        if (rxByte == 8'h02)
          strb.home = 1'b1;
        else if (rxByte[7] && ({1'b0, rxByte[6:0]} < DEPTH_B))
          strb.setAddr = 1'b1;
      end
      if (state == ST_READ) begin
        if (sclFall && bitCnt >= 4'd1 && bitCnt < BIT_LAST) strb.txShift = 1'b1;
        if (sclRise && bitCnt == BIT_LAST && !sdaS)         strb.fetch   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      sdaLow <= 1'b0;
      coFlag <= 1'b0;
      rsFlag <= 1'b0;
      rwFlag <= 1'b0;
    end else if (stopEv) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      sdaLow <= 1'b0;
    end else if (startEv) begin
      state  <= ST_ADDR;
      bitCnt <= '0;
      sdaLow <= 1'b0;
    end else if (isRecv) begin
      if (sclRise && bitCnt < BIT_LAST) begin
        bitCnt <= bitCnt + 4'd1;
      end else if (sclFall && bitCnt == BIT_LAST) begin
        bitCnt <= BIT_ACK;
        sdaLow <= 1'b1;
        unique case (state)
          ST_ADDR: begin
            if (!addrHit || (rxByte[0] && !readOk)) begin
              state  <= ST_WAIT;
              sdaLow <= 1'b0;
            end else if (rxByte[0]) begin
              state <= ST_READ;
            end else begin
              state <= ST_CTRL;
            end
          end
          ST_CTRL: begin
            coFlag <= rxByte[7];
            rsFlag <= rxByte[6];
            rwFlag <= rxByte[5];
            state  <= ST_PAY;
          end
          default: state <= coFlag ? ST_CTRL : ST_PAY;
        endcase
      end else if (sclFall && bitCnt == BIT_ACK) begin
        bitCnt <= '0;
        sdaLow <= 1'b0;
      end
    end else if (state == ST_READ) begin
      if (sclRise && bitCnt < BIT_LAST) begin
        bitCnt <= bitCnt + 4'd1;
      end else if (sclRise && bitCnt == BIT_LAST) begin
        if (sdaS) state  <= ST_WAIT;
        else      bitCnt <= BIT_ACK;
      end else if (sclFall) begin
        if (bitCnt == BIT_ACK) begin
          bitCnt <= '0;
          sdaLow <= ~txHead[1];
        end else if (bitCnt == BIT_LAST) begin
          sdaLow <= 1'b0;
        end else if (bitCnt >= 4'd1) begin
          sdaLow <= ~txHead[0];
        end
      end
    end
  end

endmodule

// File: rtl/disp_i2c_slave.sv
module disp_i2c_slave
  import disp_i2c_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR  = 7'b0111010,
  parameter int         DEPTH       = 80,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sdaOe,
  output logic [6:0] ramAddr,
  input  logic [7:0] ramData
);

  dpStrobe_t  strb;
  busState_t  ctlState;
  logic [7:0] rxByte;
  logic [1:0] txHead;
  logic       sdaBit, sclLevel, stopEv, rsFlag, rwFlag;

  disp_i2c_ctrl #(
    .SLAVE_ADDR (SLAVE_ADDR),
    .DEPTH      (DEPTH),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .sclIn   (sclIn),
    .sdaIn   (sdaIn),
    .rxByte  (rxByte),
    .txHead  (txHead),
    .sdaOe   (sdaOe),
    .sdaBit  (sdaBit),
    .strb    (strb),
    .state   (ctlState),
    .sclLevel(sclLevel),
    .stopEv  (stopEv),
    .rsFlag  (rsFlag),
    .rwFlag  (rwFlag)
  );

  disp_i2c_dpath #(
    .DEPTH(DEPTH)
  ) u_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .sdaBit (sdaBit),
    .ramData(ramData),
    .rxByte (rxByte),
    .txHead (txHead),
    .ramAddr(ramAddr)
  );

endmodule

// File: rtl/disp_i2c_checker.sv
module disp_i2c_checker
  import disp_i2c_pkg::*;
#(
  parameter int DEPTH = 80
) (
  input logic       clk,
  input logic       rstN,
  input logic       sdaOe,
  input logic [6:0] ramAddr,
  input busState_t  state,
  input logic       sclLevel,
  input logic       stopEv,
  input logic       rsFlag,
  input logic       rwFlag,
  input logic       fetch
);

  localparam logic [6:0] LAST_LOC = 7'(DEPTH - 1);

  p_addr_range_r4: assert property (@(posedge clk) disable iff (!rstN)
    ramAddr <= LAST_LOC);

  p_fetch_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    fetch |=> ramAddr == (($past(ramAddr) == LAST_LOC) ? 7'd0 : $past(ramAddr) + 7'd1));

  p_nack_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT) |=> $stable(ramAddr));

  p_sda_scl_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclLevel);

  p_stop_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    stopEv |=> (state == ST_IDLE) && !sdaOe);

  p_read_gate_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_READ) ##1 (state == ST_READ) |-> rsFlag && rwFlag);

endmodule

bind disp_i2c_slave disp_i2c_checker #(.DEPTH(DEPTH)) chk (
  .clk     (clk),
  .rstN    (rstN),
  .sdaOe   (sdaOe),
  .ramAddr (ramAddr),
  .state   (ctlState),
  .sclLevel(sclLevel),
  .stopEv  (stopEv),
  .rsFlag  (rsFlag),
  .rwFlag  (rwFlag),
  .fetch   (strb.fetch)
);

// File: tb/disp_i2c_slave_test.sv
module disp_i2c_slave_test;

  logic       clk = 1'b0;
  logic       rstN;
  logic       scl;
  logic       sdaM;
  logic       sdaOe;
  logic [6:0] ramAddr;
  logic [7:0] ramData;
  wire        sdaBus = sdaM & ~sdaOe;

  logic [7:0] ram [0:79];
  int         nChecks = 0;
  int         nFail   = 0;
  bit         done    = 1'b0;
  logic [6:0] acExp;
  logic [7:0] drExp;

  always #10 clk = ~clk;

  assign ramData = (ramAddr < 7'd80) ? ram[ramAddr] : 8'h00;

  disp_i2c_slave uut (
    .clk    (clk),
    .rstN   (rstN),
    .sclIn  (scl),
    .sdaIn  (sdaBus),
    .sdaOe  (sdaOe),
    .ramAddr(ramAddr),
    .ramData(ramData)
  );

  function automatic logic [6:0] wrapNext(input logic [6:0] a);
    return (a == 7'd79) ? 7'd0 : a + 7'd1;
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; tick(5); scl = 1'b1; tick(10);
    sdaM = 1'b0; tick(10); scl = 1'b0; tick(5);
  endtask

  task automatic busStop();
    sdaM = 1'b0; tick(5); scl = 1'b1; tick(10);
    sdaM = 1'b1; tick(10);
  endtask

  task automatic sendBit(input logic b);
    sdaM = b; tick(5); scl = 1'b1; tick(10); scl = 1'b0; tick(5);
  endtask

  task automatic writeByte(input logic [7:0] v, output logic ack);
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
    sdaM = 1'b1; tick(5); scl = 1'b1; tick(5);
    ack = !sdaBus;
    tick(5); scl = 1'b0; tick(5);
  endtask

  task automatic wrAck(input logic [7:0] v, input string req);
    logic a;
    writeByte(v, a);
    check(a, req, a, 1);
  endtask

  task automatic readByte(input logic mAck, output logic [7:0] v);
    v = '0;
    for (int i = 0; i < 8; i++) begin
      sdaM = 1'b1; tick(5); scl = 1'b1; tick(5);
      v = {v[6:0], sdaBus};
      tick(5); scl = 1'b0; tick(5);
    end
    sdaM = !mAck; tick(5); scl = 1'b1; tick(5);
    check(!sdaOe, "R6 master ack slot released", sdaOe, 0);
    tick(5); scl = 1'b0; tick(5);
    sdaM = 1'b1;
  endtask

  task automatic doSet(input logic [6:0] a);
    busStart();
    wrAck(8'h74, "R1 write address");
    wrAck(8'h80, "R2 control Co=1 RS=0");
    wrAck({1'b1, a}, "R4 set address acked");
    busStop();
    if (a < 7'd80) begin
      drExp = ram[a];
      acExp = wrapNext(a);
    end
    check(ramAddr == acExp, "R4 counter after set address", ramAddr, acExp);
  endtask

  task automatic readBurst(input int k);
    logic [7:0] b, exp;
    busStart();
    wrAck(8'h74, "R1 write address");
    wrAck(8'h60, "R2 control Co=0 RS=1 RW=1");
    busStart();
    wrAck(8'h75, "R5 read address acked");
    exp = drExp;
    for (int j = 0; j < k; j++) begin
      readByte(j < k - 1, b);
      check(b == exp, (j == 0) ? "R6 first byte is data register" : "R7 prefetched byte",
            b, exp);
      if (j < k - 1) begin
        drExp = ram[acExp];
        exp   = drExp;
        acExp = wrapNext(acExp);
      end
    end
    busStop();
    check(ramAddr == acExp, "R8 counter held after nack", ramAddr, acExp);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] b;
    int seedVal;
    seedVal = $urandom(32'd20240611);
    for (int i = 0; i < 80; i++) ram[i] = 8'($urandom());
    rstN = 1'b0; scl = 1'b1; sdaM = 1'b1;
    acExp = '0; drExp = '0;
    tick(6);
    check(!sdaOe, "R10 SDA released in reset", sdaOe, 0);
    check(ramAddr == 7'd0, "R10 counter zero in reset", ramAddr, 0);
    rstN = 1'b1;
    tick(6);

    // R10: data register cleared, first byte after reset is 0x00
    readBurst(2);

    // R1: foreign address ignored until next START
    busStart();
    writeByte(8'h76, a);
    check(!a, "R1 foreign address not acked", a, 0);
    writeByte(8'h80, a);
    check(!a, "R1 bytes after mismatch ignored", a, 0);
    writeByte(8'h85, a);
    busStop();
    check(ramAddr == acExp, "R1 counter unchanged after mismatch", ramAddr, acExp);

    // R4: wrap at the last location
    doSet(7'd79);
    readBurst(3);

    // R4: out-of-range operand ignored
    doSet(7'd80);
    check(ramAddr == acExp, "R4 operand 80 ignored", ramAddr, acExp);

    // R3: return home keeps data register
    doSet(7'd10);
    busStart();
    wrAck(8'h74, "R1 write address");
    wrAck(8'h80, "R2 control Co=1");
    wrAck(8'h02, "R3 return home acked");
    busStop();
    acExp = 7'd0;
    check(ramAddr == 7'd0, "R3 counter home", ramAddr, 0);
    readBurst(2);

    // R5: read refused when control byte had RW=0
    doSet(7'd20);
    busStart();
    wrAck(8'h74, "R1 write address");
    wrAck(8'h40, "R2 control RS=1 RW=0");
    busStart();
    writeByte(8'h75, a);
    check(!a, "R5 read refused without RW", a, 0);
    busStop();
    check(ramAddr == acExp, "R5 counter unchanged", ramAddr, acExp);

    // R2: Co=0 stream of instructions
    busStart();
    wrAck(8'h74, "R1 write address");
    wrAck(8'h00, "R2 control Co=0 RS=0");
    wrAck(8'h85, "R2 stream instr 1");
    wrAck(8'h02, "R2 stream instr 2");
    wrAck(8'h8C, "R2 stream instr 3");
    busStop();
    drExp = ram[12]; acExp = 7'd13;
    check(ramAddr == acExp, "R2 Co=0 stream executed", ramAddr, acExp);

    // R2/R11: Co=1 then a control byte selecting data; data ignored
    busStart();
    wrAck(8'h74, "R1 write address");
    wrAck(8'h80, "R2 control Co=1");
    wrAck(8'h02, "R3 home in Co=1 pair");
    wrAck(8'hC0, "R2 second control byte");
    wrAck(8'h90, "R11 data byte acked");
    busStop();
    acExp = 7'd0;
    check(ramAddr == 7'd0, "R2 byte after pair parsed as control", ramAddr, 0);

    // R11: data stream and unknown instruction leave counter alone
    doSet(7'd33);
    busStart();
    wrAck(8'h74, "R1 write address");
    wrAck(8'h40, "R11 control RS=1");
    wrAck(8'h8A, "R11 data 1");
    wrAck(8'h02, "R11 data 2");
    busStop();
    busStart();
    wrAck(8'h74, "R1 write address");
    wrAck(8'h00, "R11 control RS=0");
    wrAck(8'h01, "R11 unknown instruction");
    busStop();
    check(ramAddr == acExp, "R11 counter unchanged", ramAddr, acExp);
    readBurst(2);

    // R9: STOP mid-byte, then new START acked
    busStart();
    sendBit(1'b0); sendBit(1'b1); sendBit(1'b1);
    busStop();
    check(!sdaOe, "R9 SDA released after STOP", sdaOe, 0);
    busStart();
    writeByte(8'h74, a);
    check(a, "R9 address acked after STOP", a, 1);
    busStop();

    // R8: after nack the slave stays silent
    doSet(7'd5);
    busStart();
    wrAck(8'h74, "R1 write address");
    wrAck(8'h60, "R2 control read");
    busStart();
    wrAck(8'h75, "R5 read address acked");
    readByte(1'b0, b);
    check(b == drExp, "R6 byte before nack", b, drExp);
    readByte(1'b0, b);
    check(b == 8'hFF, "R8 bus released after nack", b, 8'hFF);
    busStop();
    check(ramAddr == acExp, "R8 counter unchanged", ramAddr, acExp);

    // random set-address / burst reads
    for (int it = 0; it < 20; it++) begin
      if ($urandom_range(0, 5) == 0) begin
        busStart();
        wrAck(8'h74, "R1 write address");
        wrAck(8'h80, "R2 control Co=1");
        wrAck(8'h02, "R3 home");
        busStop();
        acExp = 7'd0;
      end else begin
        doSet(7'($urandom_range(0, 79)));
      end
      readBurst($urandom_range(1, 5));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule